// File: doc/BRIEF.md
# Wrapped Sub-block Line Buffer

This block holds one 64-byte cache line and passes it from a processor-side bus to a system-side bus as four 16-byte sub-blocks. The producer loads the sub-blocks in any order through an indexed write port. Each sub-block has a valid bit, and a transfer cannot begin until all four bits are set.

A request names a transfer type and a critical sub-block index. For reads and snoop copy-backs, the critical sub-block goes out first. The rest follow in ascending index order and wrap past the top of the line. A writeback ignores the requested index and always starts at sub-block 0. The buffer moves whole sub-blocks only and never changes the bytes inside one.

Beats leave on a valid/ready stream. Each beat carries its sub-block index, and the fourth beat carries a last flag. When the last beat is accepted, the line is released and all valid bits clear.

Top module: `wrap_line_buf`

## Requirements
- R1: After reset, `busy`, `out_valid` and `req_ready` are all low.
- R2: `req_ready` is high only when the buffer is idle and all four sub-blocks have been written. A request with `req_valid` high is accepted at the clock edge where `req_ready` is high. From the next cycle, `busy` and `out_valid` are high.
- R3: For a read (`req_type` 2'b00, and also the reserved code 2'b11), the first beat carries `out_idx` equal to `req_idx`. Every later beat carries the previous index plus one, modulo 4.
- R4: For a snoop copy-back (`req_type` 2'b01), the order is the same as for a read: the requested index first, then ascending with wraparound.
- R5: For a writeback (`req_type` 2'b10), the beats carry indices 0, 1, 2, 3 in that order, whatever `req_idx` is.
- R6: The `out_data` of each beat equals, bit for bit, the 128-bit word last written to the sub-block named by `out_idx`.
- R7: `out_last` is high on the fourth beat of a transfer and low on the first three. In the cycle after the fourth beat is accepted, `out_valid` and `busy` are low.
- R8: While `out_valid` is high and `out_ready` is low, the beat holds: `out_valid`, `out_idx`, `out_last` and `out_data` keep their values.
- R9: Writes presented while `busy` is high are ignored. They change neither the data delivered nor the valid bits.
- R10: Completing a transfer clears all four valid bits. `req_ready` stays low until all four sub-blocks are written again.
- R11: A request presented while `req_ready` is low is ignored. `busy` stays low and no beat appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sub-block write strobe |
| wr_idx | input | 2 | Index of the sub-block being written |
| wr_data | input | 128 | Sub-block write data |
| req_valid | input | 1 | Transfer request strobe |
| req_type | input | 2 | 00 read, 01 snoop, 10 writeback, 11 treated as read |
| req_idx | input | 2 | Critical sub-block index |
| req_ready | output | 1 | Line complete and buffer idle |
| busy | output | 1 | Transfer in progress |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 128 | Sub-block data |
| out_idx | output | 2 | Sub-block index of the beat |
| out_last | output | 1 | Fourth beat of the transfer |

## Verification
The bench covers every starting index for each transfer type, so wraparound is exercised from every start point. A design that wrapped incorrectly would show up as a duplicated sub-block or as an index of 4 truncated to a wrong value. Writebacks are requested with nonzero critical indices, which catches a design that honours `req_idx` for writebacks. Random backpressure catches a sequencer that moves its pointer without a handshake: it would skip or repeat a beat. Writes during a transfer, requests against a partial line, and requests after a completed line catch a buffer that lets stale or half-written lines go out, or that corrupts a line already being sent.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
  typedef enum logic [1:0] {
    XF_READ  = 2'b00,
    XF_SNOOP = 2'b01,
    XF_WBACK = 2'b10,
    XF_RSVD  = 2'b11
  } xfer_e;

  // Writebacks always begin at sub-block zero; all other kinds begin at the critical index.
  function automatic logic fixed_start(input logic [1:0] kind);
    return kind == XF_WBACK;
  endfunction
endpackage

// File: rtl/wlb_store.sv
module wlb_store #(
  parameter int DATA_W = 128,
  parameter int NSUB   = 4,
  localparam int IDX_W = $clog2(NSUB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              full
);
  logic [DATA_W-1:0] mem [NSUB];
  logic [NSUB-1:0]   vld;
  logic              wr_ok;

  assign wr_ok = wr_en && !lock;
  assign full  = &vld;

  // Plain RAM: synchronous write, registered read, no reset on data.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (wr_ok) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  // R9
  lock_keeps_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && !clr) |=> $stable(vld));

  // R10
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld == '0));
endmodule

// File: rtl/wlb_seq.sv
module wlb_seq
  import wlb_pkg::*;
#(
  parameter int NSUB   = 4,
  localparam int IDX_W = $clog2(NSUB),
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(NSUB - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             out_ready,
  output logic             req_ready,
  output logic             busy,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_last,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             clr
);
  logic             load, adv;
  logic [IDX_W-1:0] start, nxt;
  logic [IDX_W-1:0] cnt;

  assign req_ready = full && !busy;
  assign load      = req_valid && req_ready;
  assign adv       = out_valid && out_ready;
  assign start     = fixed_start(req_type) ? '0 : req_idx;
  // NSUB is a power of two, so the increment wraps at the line boundary.
  assign nxt       = out_idx + 1'b1;
  assign clr       = adv && out_last;

  always_comb begin
    rd_en  = 1'b0;
    rd_idx = start;
    if (load) begin
      rd_en = 1'b1;
    end else if (adv && !out_last) begin
      rd_en  = 1'b1;
      rd_idx = nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_last  <= 1'b0;
      cnt       <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      out_valid <= 1'b1;
      out_idx   <= start;
      out_last  <= (LAST_CNT == '0);
      cnt       <= '0;
    end else if (adv) begin
      if (out_last) begin
        busy      <= 1'b0;
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end else begin
        out_idx  <= nxt;
        cnt      <= cnt + 1'b1;
        out_last <= (cnt + 1'b1 == LAST_CNT);
      end
    end
  end

  // R2
  load_starts_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && out_valid));

  // R5
  wback_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load && req_type == 2'b10) |=> (out_idx == '0));

  // R3
  wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !out_last) |=> (out_valid && out_idx == IDX_W'($past(out_idx) + 1'b1)));

  // R8
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_last)));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && out_last) |=> (!out_valid && !busy));
endmodule

// File: rtl/wrap_line_buf.sv
module wrap_line_buf #(
  parameter int DATA_W = 128,
  parameter int NSUB   = 4,
  localparam int IDX_W = $clog2(NSUB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              req_ready,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  out_idx,
  output logic              out_last
);
  logic             full, clr, rd_en;
  logic [IDX_W-1:0] rd_idx;

  wlb_seq #(.NSUB(NSUB)) u_seq (
    .clk(clk), .rst(rst), .full(full),
    .req_valid(req_valid), .req_type(req_type), .req_idx(req_idx),
    .out_ready(out_ready), .req_ready(req_ready), .busy(busy),
    .out_valid(out_valid), .out_idx(out_idx), .out_last(out_last),
    .rd_en(rd_en), .rd_idx(rd_idx), .clr(clr)
  );

  wlb_store #(.DATA_W(DATA_W), .NSUB(NSUB)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lock(busy), .clr(clr), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(out_data), .full(full)
  );

  // R11
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(req_valid && req_ready)) |=> !out_valid);
endmodule

// File: tb/wrap_line_buf_tb.sv
module wrap_line_buf_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en, req_valid, out_ready;
  logic [1:0]   wr_idx, req_type, req_idx;
  logic [127:0] wr_data;
  logic         req_ready, busy, out_valid, out_last;
  logic [127:0] out_data;
  logic [1:0]   out_idx;

  int checks = 0;
  int errors = 0;
  logic [127:0] line [4];
  int cyc = 0;

  always #10 clk = ~clk;

  wrap_line_buf u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_type(req_type), .req_idx(req_idx),
    .req_ready(req_ready), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_idx(input logic [1:0] kind, input logic [1:0] crit, input int k);
    logic [1:0] s;
    s = (kind == 2'b10) ? 2'd0 : crit;
    return s + 2'(k);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic write_sub(input logic [1:0] i, input logic [127:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill_line();
    int base;
    base = $urandom_range(0, 3);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] i;
      i = 2'(base + k);
      line[i] = rnd128();
      write_sub(i, line[i]);
    end
  endtask

  task automatic run_xfer(input logic [1:0] kind, input logic [1:0] crit, input int stall_max, input bit poke);
    chk(req_ready == 1'b1, "R2 ready on full line", 128'(req_ready), 128'd1);
    req_valid = 1'b1; req_type = kind; req_idx = crit;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(busy && out_valid, "R2 start", 128'({busy, out_valid}), 128'd3);
    for (int k = 0; k < 4; k++) begin
      int st;
      logic [1:0] ei;
      ei = exp_idx(kind, crit, k);
      st = (stall_max > 0) ? $urandom_range(0, stall_max) : 0;
      for (int s = 0; s < st; s++) begin
        out_ready = 1'b0;
        if (poke) begin
          wr_en = 1'b1; wr_idx = 2'($urandom); wr_data = rnd128();
        end
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk(out_valid && out_idx == ei, "R8 hold", 128'(out_idx), 128'(ei));
      end
      chk(out_valid == 1'b1, "R7 valid", 128'(out_valid), 128'd1);
      if (kind == 2'b10)
        chk(out_idx == ei, "R5 index", 128'(out_idx), 128'(ei));
      else if (kind == 2'b01)
        chk(out_idx == ei, "R4 index", 128'(out_idx), 128'(ei));
      else
        chk(out_idx == ei, "R3 index", 128'(out_idx), 128'(ei));
      chk(out_data == line[ei], poke ? "R9 data" : "R6 data", out_data, line[ei]);
      chk(out_last == (k == 3), "R7 last", 128'(out_last), 128'(k == 3));
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0;
    end
    chk(!out_valid && !busy, "R7 end", 128'({out_valid, busy}), 128'd0);
    chk(req_ready == 1'b0, "R10 cleared", 128'(req_ready), 128'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 0; req_valid = 0; out_ready = 0;
    wr_idx = 0; req_type = 0; req_idx = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !out_valid && !req_ready, "R1 reset", 128'({busy, out_valid, req_ready}), 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // R11: partial line, request must be ignored
    line[0] = rnd128(); write_sub(2'd0, line[0]);
    line[2] = rnd128(); write_sub(2'd2, line[2]);
    chk(req_ready == 1'b0, "R2 partial", 128'(req_ready), 128'd0);
    req_valid = 1'b1; req_type = 2'b00; req_idx = 2'd2;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(!busy && !out_valid, "R11 ignored", 128'({busy, out_valid}), 128'd0);
    line[1] = rnd128(); write_sub(2'd1, line[1]);
    line[3] = rnd128(); write_sub(2'd3, line[3]);
    run_xfer(2'b00, 2'd2, 0, 0);

    // R10: request after completion without refill is ignored
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(!busy && !out_valid, "R10 no restart", 128'({busy, out_valid}), 128'd0);

    // Directed: every type and every start index
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 4; c++) begin
        fill_line();
        run_xfer(2'(t), 2'(c), 0, 0);
      end

    // Random with backpressure and writes while busy
    for (int n = 0; n < 40; n++) begin
      fill_line();
      run_xfer(2'($urandom), 2'($urandom), 3, ($urandom_range(0, 1) == 1));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule